// File: doc/BRIEF.md
# I2C Register Slave

This block is a serial slave on a two-wire bus. Through it, a bus master reads and writes a bank of 16-bit registers. The two bus lines, clock and data, are brought into the system clock domain and watched for bus conditions and clock edges. The system clock must run at least 16 times faster than the bus clock. No setting depends on the bus speed, so any bus rate up to 400 kHz works without configuration.

A master starts a write with the device address and the write direction. It then sends one byte that sets the register pointer, followed by pairs of data bytes. A read starts the same way but uses the read direction. Reads normally follow a pointer write and a repeated START. The slave returns the low byte and then the high byte of each register, and the pointer advances after every pair. The data line is driven only by pulling it low through an output-enable signal.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. After a STOP the slave is idle, releases the data line and accepts a following transaction.
- R2: A repeated START is accepted at any point. It abandons the current transfer, including a half-received byte pair, and begins a new address phase in which the next write byte is again a pointer.
- R3: Only the 7-bit address 0110110 is acknowledged; the first byte is 0x6C for a write and 0x6D for a read. Any other address gets no acknowledge. The data line then stays released until the next START or STOP, and no register changes.
- R4: The eighth bit of the address byte selects the direction: 0 means the master writes, 1 means the master reads.
- R5: Each byte travels most significant bit first, and the acknowledge slot is the ninth clock pulse.
- R6: In a write, the first byte after the address sets the pointer; only its low log2(NUM_REGS) bits count and the upper bits are ignored. Each later pair carries the low byte and then the high byte. The register is written when the high byte arrives, and the pointer then increments, wrapping modulo NUM_REGS. A low byte without its high byte changes nothing.
- R7: The slave pulls the data line low across the whole ninth pulse after a matching address and after every byte it receives. It releases the line after that pulse falls.
- R8: The data output changes only while the clock line is low. The only exceptions are releases caused by a START or a STOP. The level seen on the bus stays stable through every clock-high period.
- R9: In a read, the slave sends the low byte and then the high byte of the register at the pointer. At the end of each high byte's acknowledge slot, whether the master acknowledged or not, the pointer increments modulo NUM_REGS.
- R10: When the master does not acknowledge a byte it read, the slave stops driving the data line until the next START or STOP.
- R11: After reset all registers read 0, the pointer is 0, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the bus |
| sda_i | input | 1 | Bus data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The checker watches four things on every cycle: that the data output moves only while the synchronized clock line is low, that START and STOP put the slave into its address state and idle state, and that the slave never drives the line when it is idle, ignoring the bus, or in a slot that belongs to the master. Other behaviours only show in the bench's scenarios, which drive the bus as a master. These are address matching, pointer handling, low-byte-first ordering, discarding of a half-written pair, pointer wrap, and the release after a master NACK. The bench checks them by reading the bank back over the bus and comparing against its own model.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam logic [6:0] DEV_ADDR = 7'b0110110;
    localparam int         BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    typedef enum logic [1:0] {
        WP_PTR,
        WP_LO,
        WP_HI
    } wr_phase_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == DEV_ADDR;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = chain[STAGES-1] & ~prev;
        ev.fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 16,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_reg_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int PTR_W   = $clog2(NUM_REGS),
    localparam int WORD_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          scl,
    input  line_ev_t          sda,
    input  logic [WORD_W-1:0] rdata,
    output logic [PTR_W-1:0]  raddr,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [WORD_W-1:0] wdata,
    output logic              sda_oe,
    output slv_state_e        state,
    output logic              start_ev,
    output logic              stop_ev
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] lo_hold;
    logic [3:0]        bitcnt;
    logic [PTR_W-1:0]  ptr;
    logic              rw;
    logic              hi_sel;
    logic              mack;
    wr_phase_e         phase;
    logic [BYTE_W-1:0] next_byte;

    assign start_ev = scl.level & sda.fall;
    assign stop_ev  = scl.level & sda.rise;

    // Pointer plus one is looked up while the high byte's ack slot is open
    assign raddr     = (state == ST_RD_ACK && hi_sel) ? PTR_W'(ptr + 1'b1) : ptr;
    assign next_byte = hi_sel ? rdata[BYTE_W-1:0] : rdata[WORD_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            lo_hold <= '0;
            bitcnt  <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            hi_sel  <= 1'b0;
            mack    <= 1'b0;
            phase   <= WP_PTR;
            sda_oe  <= 1'b0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
        end else begin
            we <= 1'b0;
            if (start_ev) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                phase  <= WP_PTR;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda.level};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl.fall && bitcnt == 4'(BYTE_W)) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg)) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                                unique case (phase)
                                    WP_PTR: begin
                                        ptr   <= shreg[PTR_W-1:0];
                                        phase <= WP_LO;
                                    end
                                    WP_LO: begin
                                        lo_hold <= shreg;
                                        phase   <= WP_HI;
                                    end
                                    default: begin
                                        we    <= 1'b1;
                                        waddr <= ptr;
                                        wdata <= {shreg, lo_hold};
                                        ptr   <= ptr + 1'b1;
                                        phase <= WP_LO;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl.fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rdata[BYTE_W-1:0];
                                sda_oe <= ~rdata[BYTE_W-1];
                                hi_sel <= 1'b0;
                                state  <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= WP_PTR;
                                state  <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl.fall) begin
                            if (bitcnt == 4'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl.rise) begin
                            mack <= ~sda.level;
                        end else if (scl.fall) begin
                            if (hi_sel) ptr <= ptr + 1'b1;
                            if (mack) begin
                                shreg  <= next_byte;
                                sda_oe <= ~next_byte[BYTE_W-1];
                                hi_sel <= ~hi_sel;
                                state  <= ST_RD_BYTE;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PTR_W  = $clog2(NUM_REGS);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int LINES  = 2;

    logic [LINES-1:0] pins;
    line_ev_t         lev [LINES];

    assign pins = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (pins[g]),
            .ev  (lev[g])
        );
    end

    logic              we;
    logic [PTR_W-1:0]  waddr, raddr;
    logic [WORD_W-1:0] wdata, rdata;
    slv_state_e        state_w;
    logic              start_w, stop_w, scl_lvl_w;

    assign scl_lvl_w = lev[0].level;

    i2c_slave_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl      (lev[0]),
        .sda      (lev[1]),
        .rdata    (rdata),
        .raddr    (raddr),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .sda_oe   (sda_oe),
        .state    (state_w),
        .start_ev (start_w),
        .stop_ev  (stop_w)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(WORD_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
    import i2c_reg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       start_ev,
    input logic       stop_ev,
    input slv_state_e state,
    input logic       sda_oe
);
    // R8: output only moves while the synchronized clock line is low, or on a START/STOP release
    a_r8_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start_ev) || $past(stop_ev)));

    // R1: a STOP returns the slave to idle
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_ev && !start_ev |=> state == ST_IDLE);

    // R2: a START, repeated or not, opens an address phase
    a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> state == ST_ADDR);

    // R3: released while idle or ignoring the bus
    a_r3_quiet_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    // R7: the line is driven only in slave-owned slots
    a_r7_drive_slots: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD_BYTE));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl_w),
    .start_ev (start_w),
    .stop_ev  (stop_w),
    .state    (state_w),
    .sda_oe   (sda_oe)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int Q    = 6;
    localparam int NREG = 16;
    localparam logic [7:0] AW = 8'h6C;
    localparam logic [7:0] AR = 8'h6D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [15:0] exp_regs [NREG];
    logic [15:0] stage [NREG];
    int          exp_ptr = 0;

    always #10 clk = ~clk;

    i2c_reg_slave i_i2c_reg_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m = 1'b1; scl = 1'b1; qw(1);
        sda_m = 1'b0; qw(1);
        scl = 1'b0; qw(1);
    endtask

    task automatic b_rstart();
        sda_m = 1'b1; qw(1);
        scl = 1'b1; qw(1);
        sda_m = 1'b0; qw(1);
        scl = 1'b0; qw(1);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; qw(1);
        scl = 1'b1; qw(1);
        sda_m = 1'b1; qw(1);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; qw(1);
        scl = 1'b1; qw(2);
        scl = 1'b0; qw(1);
    endtask

    task automatic rbit(output logic b);
        logic a;
        sda_m = 1'b1; qw(1);
        scl = 1'b1; qw(1);
        a = sda_bus; qw(1);
        b = sda_bus;
        chk(a == b, "R8 stable while clock high", b, a);
        scl = 1'b0; qw(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(!give_ack);
    endtask

    task automatic do_write(input logic [7:0] p, input int n);
        bit ack;
        b_start();
        send_byte(AW, ack); chk(ack, "R3 R4 address write ack", ack, 1);
        send_byte(p, ack);  chk(ack, "R6 R7 pointer ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(stage[i][7:0], ack);  chk(ack, "R7 low byte ack", ack, 1);
            send_byte(stage[i][15:8], ack); chk(ack, "R7 high byte ack", ack, 1);
            exp_regs[(p + i) % NREG] = stage[i];
        end
        b_stop();
        exp_ptr = (p + n) % NREG;
        chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    endtask

    task automatic read_pairs(input int n, input string req);
        bit ack;
        logic [7:0] lo, hi;
        send_byte(AR, ack); chk(ack, "R4 address read ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(1'b1, lo);
            recv_byte(i != n - 1, hi);
            chk({hi, lo} == exp_regs[exp_ptr], req, {hi, lo}, exp_regs[exp_ptr]);
            exp_ptr = (exp_ptr + 1) % NREG;
        end
        b_stop();
    endtask

    task automatic do_read(input logic [7:0] p, input int n, input string req);
        bit ack;
        b_start();
        send_byte(AW, ack); chk(ack, "R3 address ack", ack, 1);
        send_byte(p, ack);  chk(ack, "R6 pointer ack", ack, 1);
        exp_ptr = p % NREG;
        b_rstart();
        read_pairs(n, req);
    endtask

    initial begin
        bit ack;
        logic b;
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) exp_regs[i] = '0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R11: reset state
        chk(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);
        b_start();
        read_pairs(1, "R11 reg0 after reset via pointer 0");

        // R6 R9 R5: sequential write and read-back
        stage[0] = 16'h8001; stage[1] = 16'h1234; stage[2] = 16'hFEDC;
        do_write(8'h05, 3);
        do_read(8'h05, 3, "R9 R5 low-first readback");

        // R6 R9: pointer wrap on write and read
        stage[0] = 16'hA5A5; stage[1] = 16'h5A5A;
        do_write(8'h0F, 2);
        do_read(8'h0F, 2, "R9 wrap readback");

        // R6: upper pointer bits ignored
        stage[0] = 16'hC0DE;
        do_write(8'hF3, 1);
        do_read(8'h03, 1, "R6 upper pointer bits ignored");

        // R3: foreign address
        b_start();
        send_byte(8'h6E, ack); chk(!ack, "R3 foreign address nack", ack, 0);
        send_byte(8'h05, ack); chk(!ack, "R3 no ack after foreign", ack, 0);
        send_byte(8'h11, ack); chk(!ack, "R3 no ack on data", ack, 0);
        send_byte(8'h22, ack); chk(!ack, "R3 no ack on data", ack, 0);
        b_stop();
        do_read(8'h05, 1, "R3 register untouched");

        // R6: lone low byte is discarded
        b_start();
        send_byte(AW, ack); send_byte(8'h07, ack);
        send_byte(8'h99, ack); chk(ack, "R7 lone low ack", ack, 1);
        b_stop();
        do_read(8'h07, 1, "R6 lone low byte ignored");

        // R2: repeated START inside a pair
        b_start();
        send_byte(AW, ack); send_byte(8'h08, ack);
        send_byte(8'hAA, ack);
        b_rstart();
        send_byte(AW, ack); chk(ack, "R2 address after repeated start", ack, 1);
        send_byte(8'h09, ack); chk(ack, "R2 pointer after repeated start", ack, 1);
        send_byte(8'h34, ack); send_byte(8'h12, ack);
        exp_regs[9] = 16'h1234;
        b_stop();
        do_read(8'h08, 2, "R2 partial pair dropped");

        // R10: master NACK on the low byte releases the line
        do_write(8'h0A, 0);
        stage[0] = 16'h0000;
        do_write(8'h0A, 1);
        b_start();
        send_byte(AW, ack); send_byte(8'h0A, ack);
        b_rstart();
        send_byte(AR, ack);
        recv_byte(1'b0, v);
        chk(v == 8'h00, "R10 low byte before nack", v, 0);
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            chk(b == 1'b1, "R10 line released after nack", b, 1);
        end
        b_stop();

        // Random write/read-back
        for (int it = 0; it < 12; it++) begin
            int p, n;
            p = $urandom % 256;
            n = 1 + $urandom % 3;
            for (int i = 0; i < n; i++) stage[i] = 16'($urandom);
            do_write(8'(p), n);
            do_read(8'(p), n, "R6 R9 random readback");
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule